// File: doc/BRIEF.md
# Subvector Swizzle Unit

This block assembles one destination subvector of up to four 32-bit elements. Each destination lane has its own selector code. The code can copy any element (x, y, z or w) of a first source subvector or a second source subvector, in any order and with repeats. It can also insert the constant zero or the constant one, or leave that lane as it was. For "leave as it was", the lane's write-enable is dropped and the old destination element passes through. The number of destination lanes is set on its own, independent of how many source elements are read. Lanes past that count are never written.

The selector can come straight from a 16-bit selector word, together with a length input and a number-format input. It can also be unpacked from an immediate-form instruction word. In that case only the first source is used: the second source is taken to be a copy of the first. A caller that needs the single-source register form drives the same value on both source inputs. The result and the per-lane write mask are registered, and are presented one clock after the request strobe.

Top module: `vec_swizzle`

## Requirements
- R1: `out_valid` rises exactly one clock after `in_valid` is sampled high. A synchronous active-low reset clears `out_valid`, `out_data` and `out_wmask` to zero.
- R2: In the direct form, the selector of lane i is `sel_word[4i+3:4i]`. Codes 0, 1, 2 and 3 select element x, y, z or w (bits [31:0], [63:32], [95:64], [127:96]). Bit 3 clear takes the element from `src_a`, and bit 3 set takes it from `src_b`. Any source element may be used by several lanes.
- R3: Low bits 4 and 6 give zero. Low bits 5 give integer 1 when the format bit is 0, and 0x3F800000 (single-precision 1.0) when it is 1. Bit 3 has no effect on these codes.
- R4: Low bits 7 mean "unchanged": the lane's `out_wmask` bit is 0 and its `out_data` element equals the `old_dst` element.
- R5: Only lanes whose index is below the destination length are written. Lengths 5 to 7 act as 4, and length 0 writes no lane. An unwritten lane has mask bit 0 and carries `old_dst`.
- R6: With `imm_form` = 1 and `insn[14:12]` = 000, the length is `insn[30:29]`, the format bit is `insn[31]`, and lane i (i = 0..2) uses the 3-bit code in `insn[22+3i:20+3i]`. Lane 3 is not written. `src_b`, `sel_word`, `dst_len` and `fp_mode` have no effect.
- R7: With `imm_form` = 1 and `insn[14:12]` = 001 (integer) or 010 (floating point), the length is 4 and lane i (i = 0..3) uses `insn[22+3i:20+3i]`. Only `src_a` is used.
- R8: With `imm_form` = 1 and any other `insn[14:12]` value, no lane is written, and `out_data` equals `old_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| imm_form | input | 1 | 1: take selector, length and format from `insn` |
| insn | input | 32 | Immediate-form instruction word |
| sel_word | input | 16 | Direct-form selector, 4 bits per lane |
| dst_len | input | 3 | Direct-form destination length |
| fp_mode | input | 1 | Direct-form format bit, 1 = floating point |
| src_a | input | 128 | First source subvector, x in bits [31:0] |
| src_b | input | 128 | Second source subvector |
| old_dst | input | 128 | Current destination subvector |
| out_valid | output | 1 | Result strobe |
| out_data | output | 128 | New destination subvector |
| out_wmask | output | 4 | Per-lane write enable |

## Verification
The hardest case to reach is an "unchanged" code or an out-of-range lane that sits next to lanes reading the second source in reverse or repeated order. The same cycle also carries an `old_dst` that differs from every source element, so a lane that wrongly writes cannot go unnoticed. Directed patterns set up these mixes, and length values above 4 and 0, on back-to-back strobes. Immediate words with `src_b` set to a distinct pattern show that the second source is never used there. A long run of random direct and immediate requests, with the strobe dropping at random, covers the remaining combinations against a behavioural model every clock.

// File: rtl/swz_pkg.sv
// Package: shared widths, selector code values and constants of the
// swizzle unit. Assumes 32-bit elements and at most four lanes per subvector.
package swz_pkg;
    parameter int unsigned ELEM_W    = 32;
    parameter int unsigned LANES     = 4;
    parameter int unsigned CODE_W    = 4;
    parameter int unsigned IMM_CW    = 3;
    parameter int unsigned LEN_W     = 3;

    localparam logic [2:0] CODE_ZERO = 3'd4;
    localparam logic [2:0] CODE_ONE  = 3'd5;
    localparam logic [2:0] CODE_RSVD = 3'd6;
    localparam logic [2:0] CODE_KEEP = 3'd7;

    localparam logic [2:0] F3_SHORT  = 3'b000;
    localparam logic [2:0] F3_INT4   = 3'b001;
    localparam logic [2:0] F3_FP4    = 3'b010;

    localparam logic [31:0] INT_ONE  = 32'h0000_0001;
    localparam logic [31:0] FP_ONE   = 32'h3F80_0000;
endpackage

// File: rtl/swz_imm_decode.sv
// Module: swz_imm_decode
// Unpacks the per-lane selector codes, destination length and format bit
// from an immediate-form instruction word. Purely combinational.
// Assumes the 3-bit code of lane i sits at insn[20+3i +: 3]; lanes not
// covered by the word get the "unchanged" code. Unknown minor opcodes give
// length 0, so nothing is written.
module swz_imm_decode
    import swz_pkg::*;
#(
    parameter int unsigned N_LANES = LANES,
    parameter int unsigned LW      = LEN_W
) (
    input  logic [31:0]                insn,
    output logic [N_LANES*CODE_W-1:0]  sel_o,
    output logic [LW-1:0]              len_o,
    output logic                       fp_o
);
    localparam int unsigned SHORT_LANES = 3;
    localparam int unsigned FULL_LANES  = 4;
    localparam int unsigned SEL_LSB     = 20;

    logic [2:0] minor;
    logic       unused_bits;

    assign minor       = insn[14:12];
    assign unused_bits = ^{insn[19:15], insn[11:0]};

    // Decode the minor opcode into length, format and widened lane codes.
    always_comb begin
        sel_o = '1;
        len_o = '0;
        fp_o  = 1'b0;
        for (int i = 0; i < int'(N_LANES); i++) begin
            sel_o[i*CODE_W +: CODE_W] = {1'b0, CODE_KEEP};
        end
        unique case (minor)
            F3_SHORT: begin
                len_o = LW'(insn[30:29]);
                fp_o  = insn[31];
                for (int i = 0; i < int'(SHORT_LANES); i++) begin
                    if (i < int'(N_LANES))
                        sel_o[i*CODE_W +: CODE_W] = {1'b0, insn[SEL_LSB + i*IMM_CW +: IMM_CW]};
                end
            end
            F3_INT4, F3_FP4: begin
                len_o = LW'(FULL_LANES);
                fp_o  = (minor == F3_FP4);
                for (int i = 0; i < int'(FULL_LANES); i++) begin
                    if (i < int'(N_LANES))
                        sel_o[i*CODE_W +: CODE_W] = {1'b0, insn[SEL_LSB + i*IMM_CW +: IMM_CW]};
                end
            end
            default: begin
                len_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/swz_lane.sv
// Module: swz_lane
// Builds one destination element from its selector code. Assumes the
// sources are packed arrays of N_LANES elements, and that the caller has
// already tied the second source to the first in single-source modes.
module swz_lane
    import swz_pkg::*;
#(
    parameter int unsigned EW       = ELEM_W,
    parameter int unsigned N_LANES  = LANES,
    parameter int unsigned LW       = LEN_W,
    parameter int          LANE_IDX = 0
) (
    input  logic [CODE_W-1:0]             code,
    input  logic                          fp,
    input  logic [LW-1:0]                 len,
    input  logic [N_LANES-1:0][EW-1:0]    src_a,
    input  logic [N_LANES-1:0][EW-1:0]    src_b,
    input  logic [EW-1:0]                 old_elem,
    output logic [EW-1:0]                 data,
    output logic                          we
);
    logic [EW-1:0] picked;
    logic          in_range;
    logic          keep;

    assign in_range = (LANE_IDX < int'(len));
    assign keep     = (code[2:0] == CODE_KEEP);

    // Pick a source element or a constant according to the low code bits.
    always_comb begin
        picked = '0;
        if (code[2] == 1'b0) begin
            picked = code[3] ? src_b[code[1:0]] : src_a[code[1:0]];
        end else begin
            unique case (code[2:0])
                CODE_ONE:  picked = fp ? EW'(FP_ONE) : EW'(INT_ONE);
                CODE_ZERO: picked = '0;
                CODE_RSVD: picked = '0;
                default:   picked = '0;
            endcase
        end
    end

    // Write only in-range lanes that are not marked unchanged.
    always_comb begin
        we   = in_range && !keep;
        data = we ? picked : old_elem;
    end
endmodule

// File: rtl/vec_swizzle.sv
// Module: vec_swizzle (top)
// Swizzles one destination subvector from one or two source subvectors
// under per-lane selector codes. The result and write mask are registered
// one cycle after the request. Assumes the immediate form uses only the
// first source. Reset is synchronous and active low.
module vec_swizzle
    import swz_pkg::*;
#(
    parameter int unsigned EW      = ELEM_W,
    parameter int unsigned N_LANES = LANES,
    parameter int unsigned LW      = LEN_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        imm_form,
    input  logic [31:0]                 insn,
    input  logic [N_LANES*CODE_W-1:0]   sel_word,
    input  logic [LW-1:0]               dst_len,
    input  logic                        fp_mode,
    input  logic [N_LANES*EW-1:0]       src_a,
    input  logic [N_LANES*EW-1:0]       src_b,
    input  logic [N_LANES*EW-1:0]       old_dst,
    output logic                        out_valid,
    output logic [N_LANES*EW-1:0]       out_data,
    output logic [N_LANES-1:0]          out_wmask
);
    localparam int unsigned VEC_W = N_LANES * EW;

    logic [N_LANES-1:0][EW-1:0] a_arr;
    logic [N_LANES-1:0][EW-1:0] b_arr;
    logic [N_LANES-1:0][EW-1:0] b_eff;
    logic [N_LANES*CODE_W-1:0]  imm_sel;
    logic [LW-1:0]              imm_len;
    logic                       imm_fp;
    logic [N_LANES*CODE_W-1:0]  sel_eff;
    logic [LW-1:0]              len_eff;
    logic                       fp_eff;
    logic [VEC_W-1:0]           next_data;
    logic [N_LANES-1:0]         next_mask;

    assign a_arr = src_a;
    assign b_arr = src_b;

    swz_imm_decode #(.N_LANES(N_LANES), .LW(LW)) i_dec (
        .insn  (insn),
        .sel_o (imm_sel),
        .len_o (imm_len),
        .fp_o  (imm_fp)
    );

    // Choose between the direct controls and the decoded immediate controls.
    always_comb begin
        sel_eff = imm_form ? imm_sel : sel_word;
        len_eff = imm_form ? imm_len : dst_len;
        fp_eff  = imm_form ? imm_fp  : fp_mode;
        b_eff   = imm_form ? a_arr   : b_arr;
    end

    for (genvar g = 0; g < int'(N_LANES); g++) begin : g_lane
        swz_lane #(.EW(EW), .N_LANES(N_LANES), .LW(LW), .LANE_IDX(g)) i_lane (
            .code     (sel_eff[g*CODE_W +: CODE_W]),
            .fp       (fp_eff),
            .len      (len_eff),
            .src_a    (a_arr),
            .src_b    (b_eff),
            .old_elem (old_dst[g*EW +: EW]),
            .data     (next_data[g*EW +: EW]),
            .we       (next_mask[g])
        );

        // R4/R5: a lane left unwritten shows the old element it was given.
        assert_keep_old_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_wmask[g]) |-> (out_data[g*EW +: EW] == $past(old_dst[g*EW +: EW])));
    end

    // Register the result, mask and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_wmask <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data  <= next_data;
                out_wmask <= next_mask;
            end
        end
    end

    assert_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    assert_len_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(!imm_form && dst_len == LW'(1))) |-> (out_wmask[N_LANES-1:1] == '0));

    assert_bad_minor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(imm_form && insn[14:12] == 3'b111)) |-> (out_wmask == '0));

    assert_zero_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(!imm_form && sel_word[2:0] == CODE_ZERO && dst_len != '0))
        |-> (out_wmask[0] && out_data[EW-1:0] == '0));

    assert_second_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(!imm_form && sel_word[3:0] == 4'd9 && dst_len != '0))
        |-> (out_data[EW-1:0] == $past(src_b[2*EW-1:EW])));
endmodule

// File: tb/test_vec_swizzle.sv
module test_vec_swizzle;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         imm_form = 1'b0;
    logic [31:0]  insn = '0;
    logic [15:0]  sel_word = '0;
    logic [2:0]   dst_len = '0;
    logic         fp_mode = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] old_dst = '0;
    logic         out_valid;
    logic [127:0] out_data;
    logic [3:0]   out_wmask;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vec_swizzle i_vec_swizzle (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm_form(imm_form),
        .insn(insn), .sel_word(sel_word), .dst_len(dst_len), .fp_mode(fp_mode),
        .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
        .out_valid(out_valid), .out_data(out_data), .out_wmask(out_wmask)
    );

    // Behavioural model of one request.
    task automatic model(output logic [127:0] d, output logic [3:0] m);
        int codes[4];
        int n;
        bit f;
        logic [127:0] bb;
        for (int i = 0; i < 4; i++) codes[i] = 7;
        if (imm_form) begin
            bb = src_a; n = 0; f = 0;
            if (insn[14:12] == 3'b000) begin
                n = int'(insn[30:29]); f = insn[31];
                for (int i = 0; i < 3; i++) codes[i] = int'(insn[20+3*i +: 3]);
            end else if (insn[14:12] == 3'b001 || insn[14:12] == 3'b010) begin
                n = 4; f = (insn[14:12] == 3'b010);
                for (int i = 0; i < 4; i++) codes[i] = int'(insn[20+3*i +: 3]);
            end
        end else begin
            bb = src_b; n = int'(dst_len); f = fp_mode;
            for (int i = 0; i < 4; i++) codes[i] = int'(sel_word[4*i +: 4]);
        end
        for (int i = 0; i < 4; i++) begin
            int lo;
            lo = codes[i] % 8;
            if (i >= n || lo == 7) begin
                m[i] = 1'b0;
                d[32*i +: 32] = old_dst[32*i +: 32];
            end else begin
                m[i] = 1'b1;
                if (lo < 4) d[32*i +: 32] = (codes[i] >= 8) ? bb[32*lo +: 32] : src_a[32*lo +: 32];
                else if (lo == 5) d[32*i +: 32] = f ? 32'h3F80_0000 : 32'd1;
                else d[32*i +: 32] = 32'd0;
            end
        end
    endtask

    task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply current inputs for one clock (with given strobe) and compare.
    task automatic cyc(string req, bit v);
        logic [127:0] ed;
        logic [3:0]   em;
        in_valid = v;
        model(ed, em);
        @(posedge clk);
        #2;
        check(req, "out_valid", 128'(out_valid), 128'(v));
        if (v) begin
            check(req, "out_wmask", 128'(out_wmask), 128'(em));
            check(req, "out_data", out_data, ed);
        end
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk_short(bit fp, logic [1:0] len, logic [8:0] sel);
        return {fp, len, sel, 5'd3, 3'b000, 5'd4, 7'h0B};
    endfunction

    function automatic logic [31:0] mk_full(logic [2:0] f3, logic [11:0] sel);
        return {sel, 5'd3, f3, 5'd4, 7'h0B};
    endfunction

    task automatic direct(string req, logic [15:0] s, logic [2:0] l, bit fp);
        imm_form = 0; sel_word = s; dst_len = l; fp_mode = fp;
        cyc(req, 1);
    endtask

    task automatic immed(string req, logic [31:0] w);
        imm_form = 1; insn = w;
        sel_word = 16'hFFFF; dst_len = 3'd7; fp_mode = 1'b1;
        cyc(req, 1);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        src_a   = {32'hA3A3_0003, 32'hA2A2_0002, 32'hA1A1_0001, 32'hA0A0_0000};
        src_b   = {32'hB3B3_0003, 32'hB2B2_0002, 32'hB1B1_0001, 32'hB0B0_0000};
        old_dst = {32'hD3D3_0003, 32'hD2D2_0002, 32'hD1D1_0001, 32'hD0D0_0000};
        in_valid = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check("R1", "reset out_valid", 128'(out_valid), 128'(0));
        check("R1", "reset out_wmask", 128'(out_wmask), 128'(0));
        check("R1", "reset out_data", out_data, 128'(0));
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        cyc("R1", 0);

        // R2: identity, reverse from second source, repeats
        direct("R2", 16'h3210, 3'd4, 0);
        direct("R2", 16'h89AB, 3'd4, 0);
        direct("R2", 16'h0000, 3'd4, 0);
        direct("R2", 16'hB8B8, 3'd4, 0);
        // R3: constants, bit 3 ignored
        direct("R3", 16'h6545, 3'd4, 0);
        direct("R3", 16'hDCED, 3'd4, 1);
        direct("R3", 16'h5555, 3'd4, 1);
        // R4: unchanged lanes mixed with reads
        direct("R4", 16'h7F79, 3'd4, 0);
        direct("R4", 16'hF7A7, 3'd4, 1);
        // R5: lengths
        for (int l = 0; l < 8; l++) direct("R5", 16'h9AB8, 3'(l), 0);
        // R1: idle gap then back-to-back
        cyc("R1", 0);
        cyc("R1", 0);
        direct("R1", 16'h0123, 3'd4, 0);
        direct("R1", 16'h3210, 3'd2, 0);
        // R6: short immediate form, src_b ignored
        immed("R6", mk_short(0, 2'd3, {3'd3, 3'd2, 3'd1}));
        immed("R6", mk_short(1, 2'd2, {3'd0, 3'd5, 3'd7}));
        immed("R6", mk_short(0, 2'd1, {3'd1, 3'd2, 3'd5}));
        immed("R6", mk_short(1, 2'd0, {3'd1, 3'd2, 3'd3}));
        // R7: full immediate forms
        immed("R7", mk_full(3'b001, {3'd0, 3'd1, 3'd2, 3'd3}));
        immed("R7", mk_full(3'b010, {3'd5, 3'd7, 3'd4, 3'd5}));
        immed("R7", mk_full(3'b001, {3'd5, 3'd6, 3'd3, 3'd3}));
        // R8: other minor opcodes
        for (int f = 3; f < 8; f++) immed("R8", mk_full(3'(f), 12'h053));
        // R1: reset during a request
        imm_form = 0; sel_word = 16'h3210; dst_len = 3'd4; in_valid = 1'b1;
        rst_n = 1'b0;
        @(posedge clk); #2;
        check("R1", "reset mid-run out_valid", 128'(out_valid), 128'(0));
        @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0;
        cyc("R1", 0);

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            src_a   = {$urandom, $urandom, $urandom, $urandom};
            src_b   = {$urandom, $urandom, $urandom, $urandom};
            old_dst = {$urandom, $urandom, $urandom, $urandom};
            imm_form = $urandom_range(0, 2) == 0;
            insn     = $urandom;
            sel_word = 16'($urandom);
            dst_len  = 3'($urandom);
            fp_mode  = 1'($urandom);
            if (imm_form) cyc("R6", $urandom_range(0, 3) != 0);
            else cyc("R2", $urandom_range(0, 3) != 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule